// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-facing side of a descriptor-driven DMA controller. It decodes a 32-bit, word-only register bus into several identical channel banks. Each bank gets its own fixed 8 KiB address window. A bank holds the descriptor pointers, the configuration word, the command and stream-command words, and the interrupt mask. It also keeps a small raw interrupt vector, which the descriptor engine sets and software clears through a write-one-to-clear acknowledge location.

The bank tracks each channel's run state as a one-hot value. It turns register writes into single-cycle request strobes for the descriptor engine: start, load data descriptor, load context and continue. The engine reports back with pulses. One pulse sets interrupt bits, one marks the end of the list, and one restarts the channel. The engine also drives a level that shows whether the current descriptor carries its last-in-list mark. Each channel drives one level-sensitive interrupt line.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every readable location of every channel reads zero, except status, which reads 1 (state "reset"). All interrupt lines and request strobes are low.
- R2: The channel index is bus address bits [14:13] and the register offset is bits [12:0]. Writes to these offsets read back the full 32-bit value written, independently per channel: data pointer 0x00, saved descriptor 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C, command 0x80, config 0x84, mask 0x8C, stream command 0x9C.
- R3: A config write with bit 1 set moves the state to stopped (2). A config write with bit 0 clear moves it to reset (1), and this takes precedence over bit 1. A config write of bits[1:0]=01 leaves the state unchanged.
- R4: Status (0x88) reads the one-hot state in bits [2:0], the end-of-list flag in bit 5 and the channel's 8-bit stream source input in bits [15:8]. All other bits read zero.
- R5: Writing to acknowledge (0x90) clears the raw interrupt bits that are set in the written value. Acknowledge always reads zero.
- R6: Raw interrupt (0x94) reads the raw vector. Masked interrupt (0x98) reads raw AND mask. The channel's interrupt line is high exactly while the masked value is nonzero.
- R7: An interrupt-set pulse ORs its bits into the raw vector in the next cycle. A set and an acknowledge of the same bit in the same cycle leave the bit set.
- R8: A stream-command write decodes only bits [9:0]. If bit 8 or bit 6 is set, a load-data strobe is issued, and the channel also starts if bit 5 is set. If bit 9 is set, a load-context strobe is issued and the channel starts.
- R9: A start from a stream command pulses the start strobe for one cycle, sets the state to running (4) and clears the end-of-list flag. All strobes are high in the cycle after the write edge.
- R10: A command write pulses the continue strobe only when config bit 0 is 1, config bit 1 is 0, the state is running and the descriptor-eol input is high. Otherwise it issues no strobe.
- R11: An engine end-of-list pulse sets the end-of-list flag. An engine restart pulse sets the state to running and clears the flag without a start strobe.
- R12: An access with byte enables other than 4'hF, to an unmapped or misaligned offset, or to a channel index at or above the channel count raises the error output. Such an access reads zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the controller window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Rejected access, combinational |
| eng_intr_set | input | NUM_CH*INTR_W | Per-channel interrupt-set pulses |
| eng_desc_eol | input | NUM_CH | Current descriptor carries the last-in-list mark |
| eng_eol_hit | input | NUM_CH | End-of-list reached pulse |
| eng_restart | input | NUM_CH | Engine-initiated restart pulse |
| stream_src | input | NUM_CH*8 | Stream source value shown in status |
| irq | output | NUM_CH | Level interrupt per channel |
| req_start | output | NUM_CH | Start strobe |
| req_load_d | output | NUM_CH | Load data-descriptor strobe |
| req_load_c | output | NUM_CH | Load context strobe |
| req_cont | output | NUM_CH | Continue strobe |

## Verification
The bench sweeps every raw/mask pair on one channel and checks that the masked readback and the interrupt line match the AND. A design that read the mask through the acknowledge path, or left the line latched, would show a stale level. It writes every register of every channel before reading any of them back. A decoder that dropped an address bit would therefore alias banks. It tries stream-command words with only bit 6, with bit 8 plus bit 5, with bit 9, and with only bit 10. A design that started on a bare load, or that decoded bit 10, would raise a strobe where none belongs. The continue command is gated one condition at a time, and a same-cycle set and acknowledge checks that a new interrupt is not lost.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int OFF_W  = 13;
    localparam int DATA_W = 32;

    localparam logic [OFF_W-1:0] OFF_DPTR   = 13'h000;
    localparam logic [OFF_W-1:0] OFF_SDESC  = 13'h058;
    localparam logic [OFF_W-1:0] OFF_SBUF   = 13'h05C;
    localparam logic [OFF_W-1:0] OFF_GRP    = 13'h060;
    localparam logic [OFF_W-1:0] OFF_GDOWN  = 13'h07C;
    localparam logic [OFF_W-1:0] OFF_CMD    = 13'h080;
    localparam logic [OFF_W-1:0] OFF_CFG    = 13'h084;
    localparam logic [OFF_W-1:0] OFF_STAT   = 13'h088;
    localparam logic [OFF_W-1:0] OFF_MASK   = 13'h08C;
    localparam logic [OFF_W-1:0] OFF_ACK    = 13'h090;
    localparam logic [OFF_W-1:0] OFF_RAW    = 13'h094;
    localparam logic [OFF_W-1:0] OFF_MSKD   = 13'h098;
    localparam logic [OFF_W-1:0] OFF_SCMD   = 13'h09C;

    typedef enum logic [2:0] {
        ST_RST  = 3'd1,
        ST_STOP = 3'd2,
        ST_RUN  = 3'd4
    } chan_state_e;

    function automatic logic off_mapped(input logic [OFF_W-1:0] off);
        case (off)
            OFF_DPTR, OFF_SDESC, OFF_SBUF, OFF_GRP, OFF_GDOWN, OFF_CMD,
            OFF_CFG, OFF_STAT, OFF_MASK, OFF_ACK, OFF_RAW, OFF_MSKD,
            OFF_SCMD: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = OFF_W + CH_W
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic [CH_W-1:0]   ch,
    output logic [OFF_W-1:0]  off,
    output logic              ok,
    output logic              err
);
    logic ch_ok;

    always_comb begin
        ch    = addr[ADDR_W-1:OFF_W];
        off   = addr[OFF_W-1:0];
        ch_ok = (32'(ch) < NUM_CH);
        ok    = sel && (be == 4'hF) && ch_ok && off_mapped(off);
        err   = sel && !ok;
    end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_regs_pkg::*;
#(
    parameter int INTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [INTR_W-1:0] intr_set,
    input  logic              desc_eol,
    input  logic              eol_hit,
    input  logic              restart,
    input  logic [7:0]        src,
    output logic              irq,
    output logic              req_start,
    output logic              req_load_d,
    output logic              req_load_c,
    output logic              req_cont
);
    typedef struct packed {
        logic [DATA_W-1:0] dptr;
        logic [DATA_W-1:0] sdesc;
        logic [DATA_W-1:0] sbuf;
        logic [DATA_W-1:0] grp;
        logic [DATA_W-1:0] gdown;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] smd;
        logic [INTR_W-1:0] raw;
        chan_state_e       st;
        logic              eol;
        logic              s_start;
        logic              s_ld_d;
        logic              s_ld_c;
        logic              s_cont;
    } chan_t;

    chan_t q, d;
    logic  start_cmd, cfg_wr;
    logic [INTR_W-1:0] masked;

    always_comb begin
        d         = q;
        d.s_start = 1'b0;
        d.s_ld_d  = 1'b0;
        d.s_ld_c  = 1'b0;
        d.s_cont  = 1'b0;
        start_cmd = 1'b0;
        cfg_wr    = 1'b0;
        if (wr_en) begin
            case (off)
                OFF_DPTR:  d.dptr  = wdata;
                OFF_SDESC: d.sdesc = wdata;
                OFF_SBUF:  d.sbuf  = wdata;
                OFF_GRP:   d.grp   = wdata;
                OFF_GDOWN: d.gdown = wdata;
                OFF_MASK:  d.mask  = wdata;
                OFF_ACK:   d.raw   = q.raw & ~wdata[INTR_W-1:0];
                OFF_CMD: begin
                    d.cmd = wdata;
                    if (q.cfg[0] && !q.cfg[1] && q.st == ST_RUN && desc_eol)
                        d.s_cont = 1'b1;
                end
                OFF_CFG: begin
                    d.cfg  = wdata;
                    cfg_wr = 1'b1;
                    if (wdata[1])  d.st = ST_STOP;
                    if (!wdata[0]) d.st = ST_RST;
                end
                OFF_SCMD: begin
                    d.smd = wdata;
                    if (|(wdata[9:0] & 10'h140)) begin
                        d.s_ld_d = 1'b1;
                        if (wdata[5]) start_cmd = 1'b1;
                    end
                    if (wdata[9]) begin
                        d.s_ld_c  = 1'b1;
                        start_cmd = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        d.s_start = start_cmd;
        if ((start_cmd || restart) && !cfg_wr) begin
            d.st  = ST_RUN;
            d.eol = 1'b0;
        end
        d.raw = d.raw | intr_set;
        if (eol_hit) d.eol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        masked = q.raw & q.mask[INTR_W-1:0];
        case (off)
            OFF_DPTR:  rdata = q.dptr;
            OFF_SDESC: rdata = q.sdesc;
            OFF_SBUF:  rdata = q.sbuf;
            OFF_GRP:   rdata = q.grp;
            OFF_GDOWN: rdata = q.gdown;
            OFF_CMD:   rdata = q.cmd;
            OFF_CFG:   rdata = q.cfg;
            OFF_MASK:  rdata = q.mask;
            OFF_SCMD:  rdata = q.smd;
            OFF_STAT:  rdata = {16'b0, src, 2'b0, q.eol, 2'b0, q.st};
            OFF_RAW:   rdata = DATA_W'(q.raw);
            OFF_MSKD:  rdata = DATA_W'(masked);
            default:   rdata = '0;
        endcase
    end

    assign irq        = |masked;
    assign req_start  = q.s_start;
    assign req_load_d = q.s_ld_d;
    assign req_load_c = q.s_ld_c;
    assign req_cont   = q.s_cont;

    // R3: a config write with enable clear always lands in reset
    a_r3_cfg_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CFG && !wdata[0]) |=> (q.st == ST_RST));

    // R4: state is always one of the three one-hot codes
    a_r4_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(q.st));

    // R5: acknowledged bits are gone unless re-set in the same cycle
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_ACK && intr_set == '0)
        |=> ((q.raw & $past(wdata[INTR_W-1:0])) == '0));

    // R8: a context load always comes with a start
    a_r8_ctx_starts: assert property (@(posedge clk) disable iff (!rst_n)
        req_load_c |-> req_start);

    // R9: a start strobe coincides with the running state
    a_r9_start_running: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |-> (q.st == ST_RUN));

    // R10: continue is only issued from a running, enabled channel
    a_r10_cont_gate: assert property (@(posedge clk) disable iff (!rst_n)
        req_cont |-> ($past(q.st) == ST_RUN && $past(q.cfg[1:0]) == 2'b01));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int INTR_W = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = OFF_W + CH_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [3:0]               bus_be,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     bus_err,
    input  logic [NUM_CH*INTR_W-1:0] eng_intr_set,
    input  logic [NUM_CH-1:0]        eng_desc_eol,
    input  logic [NUM_CH-1:0]        eng_eol_hit,
    input  logic [NUM_CH-1:0]        eng_restart,
    input  logic [NUM_CH*8-1:0]      stream_src,
    output logic [NUM_CH-1:0]        irq,
    output logic [NUM_CH-1:0]        req_start,
    output logic [NUM_CH-1:0]        req_load_d,
    output logic [NUM_CH-1:0]        req_load_c,
    output logic [NUM_CH-1:0]        req_cont
);
    logic [CH_W-1:0]   dec_ch;
    logic [OFF_W-1:0]  dec_off;
    logic              dec_ok;
    logic [DATA_W-1:0] ch_rd [NUM_CH];

    dma_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
        .sel  (bus_sel),
        .addr (bus_addr),
        .be   (bus_be),
        .ch   (dec_ch),
        .off  (dec_off),
        .ok   (dec_ok),
        .err  (bus_err)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hit;
        assign wr_hit = dec_ok && bus_wr && (32'(dec_ch) == i);
        dma_chan_ctl #(.INTR_W(INTR_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_hit),
            .off        (dec_off),
            .wdata      (bus_wdata),
            .rdata      (ch_rd[i]),
            .intr_set   (eng_intr_set[i*INTR_W +: INTR_W]),
            .desc_eol   (eng_desc_eol[i]),
            .eol_hit    (eng_eol_hit[i]),
            .restart    (eng_restart[i]),
            .src        (stream_src[i*8 +: 8]),
            .irq        (irq[i]),
            .req_start  (req_start[i]),
            .req_load_d (req_load_d[i]),
            .req_load_c (req_load_c[i]),
            .req_cont   (req_cont[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (dec_ok && !bus_wr && 32'(dec_ch) == i) bus_rdata = ch_rd[i];
    end

    // R12: a rejected access never returns data
    a_r12_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
    localparam int NCH = 3;
    localparam int IW  = 4;
    localparam int AW  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err;
    logic [NCH*IW-1:0] eng_intr_set = '0;
    logic [NCH-1:0] eng_desc_eol = '0, eng_eol_hit = '0, eng_restart = '0;
    logic [NCH*8-1:0] stream_src = {8'hC3, 8'h5A, 8'h17};
    logic [NCH-1:0] irq, req_start, req_load_d, req_load_c, req_cont;

    int checks = 0, errors = 0;
    logic [31:0] rv;
    logic re;

    always #2.5 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err),
        .eng_intr_set(eng_intr_set), .eng_desc_eol(eng_desc_eol),
        .eng_eol_hit(eng_eol_hit), .eng_restart(eng_restart),
        .stream_src(stream_src), .irq(irq), .req_start(req_start),
        .req_load_d(req_load_d), .req_load_c(req_load_c), .req_cont(req_cont)
    );

    function automatic logic [AW-1:0] adr(input int ch, input logic [12:0] off);
        return {ch[1:0], off};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [12:0] off, input logic [31:0] v,
                      input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(ch, off);
        bus_wdata = v; bus_be = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input int ch, input logic [12:0] off, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = adr(ch, off); bus_be = be;
        #1;
        rv = bus_rdata; re = bus_err;
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    // checks the four strobes of channel ch right after a write edge
    task automatic strobes(input string req, input int ch, input logic [3:0] exp);
        chk(req, {28'b0, req_start[ch], req_load_d[ch], req_load_c[ch], req_cont[ch]},
            {28'b0, exp});
    endtask

    function automatic logic [31:0] stat(input int ch, input logic [2:0] st, input logic eol);
        return {16'b0, stream_src[ch*8 +: 8], 2'b0, eol, 2'b0, st};
    endfunction

    logic [12:0] plain [7] = '{13'h000, 13'h058, 13'h05C, 13'h060, 13'h07C, 13'h080, 13'h08C};

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 7; k++) begin
                rd(c, plain[k]); chk("R1 reg zero", rv, 32'h0);
            end
            rd(c, 13'h084); chk("R1 cfg zero", rv, 32'h0);
            rd(c, 13'h09C); chk("R1 stream zero", rv, 32'h0);
            rd(c, 13'h094); chk("R1 raw zero", rv, 32'h0);
            rd(c, 13'h088); chk("R1 status reset", rv, stat(c, 3'd1, 1'b0));
        end
        chk("R1 irq low", {29'b0, irq}, 32'h0);
        chk("R1 strobes low", {20'b0, req_start, req_load_d, req_load_c, req_cont}, 32'h0);

        // R2: write all banks first, then read all back
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 7; k++)
                wr(c, plain[k], 32'hA5000000 ^ (c << 20) ^ (32'(plain[k]) * 32'h00010101));
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 7; k++) begin
                rd(c, plain[k]);
                chk("R2 readback", rv, 32'hA5000000 ^ (c << 20) ^ (32'(plain[k]) * 32'h00010101));
            end
        for (int c = 0; c < NCH; c++) wr(c, 13'h08C, 32'h0);

        // R12: rejected accesses
        rd(0, 13'h000, 4'h7);
        chk("R12 partial read err", {31'b0, re}, 32'h1);
        chk("R12 partial read data", rv, 32'h0);
        wr(0, 13'h000, 32'hDEADBEEF, 4'h3);
        rd(0, 13'h000); chk("R12 partial write ignored", rv, 32'hA5000000);
        rd(0, 13'h004); chk("R12 unmapped err", {31'b0, re}, 32'h1);
        chk("R12 unmapped data", rv, 32'h0);
        rd(0, 13'h05A); chk("R12 misaligned err", {31'b0, re}, 32'h1);
        rd(3, 13'h000); chk("R12 bad channel err", {31'b0, re}, 32'h1);
        wr(3, 13'h09C, 32'h200);
        chk("R12 bad channel no strobe", {29'b0, req_start}, 32'h0);
        rd(1, 13'h058); chk("R12 good access no err", {31'b0, re}, 32'h0);

        // R8 / R9: stream command decode
        wr(1, 13'h09C, 32'h040); strobes("R8 bit6 load only", 1, 4'b0100);
        rd(1, 13'h088); chk("R8 no start state", rv, stat(1, 3'd1, 1'b0));
        wr(0, 13'h09C, 32'h400); strobes("R8 bit10 ignored", 0, 4'b0000);
        rd(0, 13'h088); chk("R8 bit10 state", rv, stat(0, 3'd1, 1'b0));
        rd(0, 13'h09C); chk("R2 stream readback", rv, 32'h400);
        wr(1, 13'h09C, 32'h120); strobes("R9 load+start", 1, 4'b1100);
        @(posedge clk); #1 strobes("R9 single cycle", 1, 4'b0000);
        rd(1, 13'h088); chk("R9 running", rv, stat(1, 3'd4, 1'b0));
        wr(2, 13'h09C, 32'h200); strobes("R8 context", 2, 4'b1010);
        rd(2, 13'h088); chk("R8 context running", rv, stat(2, 3'd4, 1'b0));

        // R11 / R4: end-of-list and restart
        @(negedge clk); eng_eol_hit[1] = 1'b1; @(posedge clk); #1 eng_eol_hit = '0;
        rd(1, 13'h088); chk("R4 R11 eol flag", rv, stat(1, 3'd4, 1'b1));
        wr(1, 13'h09C, 32'h020); strobes("R8 bit5 alone", 1, 4'b0000);
        rd(1, 13'h088); chk("R9 no clear without start", rv, stat(1, 3'd4, 1'b1));
        wr(1, 13'h084, 32'h3);
        rd(1, 13'h088); chk("R3 stop", rv, stat(1, 3'd2, 1'b1));
        @(negedge clk); eng_restart[1] = 1'b1; @(posedge clk); #1;
        chk("R11 restart no strobe", {31'b0, req_start[1]}, 32'h0);
        eng_restart = '0;
        rd(1, 13'h088); chk("R11 restart", rv, stat(1, 3'd4, 1'b0));
        wr(1, 13'h09C, 32'h140);
        @(negedge clk); eng_eol_hit[1] = 1'b1; @(posedge clk); #1 eng_eol_hit = '0;
        wr(1, 13'h09C, 32'h160);
        rd(1, 13'h088); chk("R9 start clears eol", rv, stat(1, 3'd4, 1'b0));

        // R3: config state moves
        wr(1, 13'h084, 32'h1);
        rd(1, 13'h088); chk("R3 enable keeps state", rv, stat(1, 3'd4, 1'b0));
        wr(1, 13'h084, 32'h2);
        rd(1, 13'h088); chk("R3 bit0 clear wins", rv, stat(1, 3'd1, 1'b0));
        rd(1, 13'h084); chk("R2 cfg readback", rv, 32'h2);

        // R10: continue gating on channel 2 (running)
        wr(2, 13'h084, 32'h1);
        wr(2, 13'h080, 32'h1); strobes("R10 no desc eol", 2, 4'b0000);
        eng_desc_eol[2] = 1'b1;
        wr(2, 13'h080, 32'h1); strobes("R10 continue", 2, 4'b0001);
        wr(2, 13'h084, 32'h3);
        wr(2, 13'h080, 32'h1); strobes("R10 stopped", 2, 4'b0000);
        wr(2, 13'h09C, 32'h200); wr(2, 13'h084, 32'h0);
        wr(2, 13'h080, 32'h1); strobes("R10 disabled", 2, 4'b0000);
        wr(2, 13'h084, 32'h1);
        wr(2, 13'h080, 32'h1); strobes("R10 not running", 2, 4'b0000);
        eng_desc_eol = '0;

        // R5 / R6 / R7: exhaustive raw x mask on channel 0
        for (int r = 0; r < 16; r++)
            for (int m = 0; m < 16; m++) begin
                wr(0, 13'h090, 32'hF);
                wr(0, 13'h08C, 32'(m));
                @(negedge clk); eng_intr_set[3:0] = 4'(r);
                @(posedge clk); #1 eng_intr_set = '0;
                rd(0, 13'h094); chk("R7 raw set", rv, 32'(r));
                rd(0, 13'h098); chk("R6 masked", rv, 32'(r & m));
                chk("R6 irq level", {31'b0, irq[0]}, {31'b0, |(r & m)});
            end
        chk("R6 other channels quiet", {30'b0, irq[2:1]}, 32'h0);
        wr(0, 13'h090, 32'hF); wr(0, 13'h08C, 32'hF);
        @(negedge clk); eng_intr_set[3:0] = 4'b0101; @(posedge clk); #1 eng_intr_set = '0;
        wr(0, 13'h090, 32'h4);
        rd(0, 13'h094); chk("R5 ack clears", rv, 32'h1);
        rd(0, 13'h090); chk("R5 ack reads zero", rv, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = adr(0, 13'h090); bus_wdata = 32'h3;
        eng_intr_set[3:0] = 4'b0010;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; eng_intr_set = '0;
        rd(0, 13'h094); chk("R7 set beats ack", rv, 32'h2);
        chk("R6 irq after set", {31'b0, irq[0]}, 32'h1);
        wr(0, 13'h090, 32'h2);
        chk("R5 irq drops", {31'b0, irq[0]}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule